// File: doc/BRIEF.md
# Register-Window DMA Burst Sequencer

This block puts a single word address, the burst window, in front of a file of 32 sixteen-bit target registers. Each read or write to the window goes to the target register at the configured start offset plus an internal index. The index then moves on by one, so a DMA channel whose peripheral address never changes can fill a run of consecutive registers, one half-word per transfer.

A configuration register holds two 5-bit fields: the start offset and a transfer-count code, where the code is the number of transfers minus one. A separate enable register arms the update path. When the path is armed, each pulse on the update-event input raises a DMA request that stays up for one complete burst. The request falls once the final window access is acknowledged. The index then returns to zero, so the next update event walks the same registers again. An update that arrives while a burst is still running is held as pending, and the request stays high for one more burst.

The target registers can also be reached directly at word addresses 0 to 31. These direct accesses never move the index.

Top module: `bdma_window_seq`

## Requirements
- R1: The configuration register is at word address 32. Its bits 12:8 hold the transfer-count code and its bits 4:0 hold the start offset. Bits 15:13 and 7:5 read as zero, and writes to them have no effect.
- R2: A transfer-count code above 17 is stored as 17. Reading the register back then shows 17 in bits 12:8.
- R3: A write to the window (word address 33) stores its data in the target register (offset + index) mod 32. A read of the window returns that register's contents.
- R4: The index is 0 after reset. Each window access (read, write or both in one cycle) advances it by exactly one.
- R5: An access at index equal to the code returns the index to 0, so one burst is code + 1 transfers. A second burst with the same configuration writes the same register sequence again.
- R6: Bit 0 of the enable register (word address 34) arms the update path. With the bit set, an update-event pulse raises dma_req at the next clock edge. With the bit clear, dma_req stays low.
- R7: dma_req stays high during the burst. It falls at the clock edge of the window access at the last index that has dma_ack high.
- R8: An update event that arrives while dma_req is high is held as pending. At the end of the current burst dma_req stays high for exactly one more burst.
- R9: A direct access at word addresses 0 to 31 reads or writes that register and leaves the index unchanged.
- R10: A write to the configuration register returns the index to 0.
- R11: After reset, all target registers, the configuration register and the enable register read 0, and dma_req is low.
- R12: Reads of word addresses 35 to 63 return 0. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 6 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as bus_re, 0 otherwise |
| upd_evt | input | 1 | Update-event pulse |
| dma_ack | input | 1 | Asserted by the DMA engine with each transfer it performs on the window |
| dma_req | output | 1 | DMA request, covers one full burst |

## Verification
A wrong index shows up at the ports on the very next window access. That access lands in the wrong target register, which a later direct read exposes, or a window read returns the wrong register's data in the same cycle. A wrong end-of-burst decision shows up one edge after the last acknowledged access: dma_req either stays high or falls early. It also leaves the index off zero, which shifts the first register of the next burst. A lost pending event shows up as dma_req falling immediately after a burst during which an update arrived.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  // Field geometry of the configuration register (positions are decoded by software).
  localparam int FIELD_W  = 5;
  localparam int LEN_LSB  = 8;
  localparam int BASE_LSB = 0;

  typedef struct packed {
    logic [FIELD_W-1:0] len_code;
    logic [FIELD_W-1:0] base_off;
  } burst_cfg_t;

  // Place the configuration fields into a 16-bit read word; reserved bits stay zero.
  function automatic logic [15:0] pack_cfg(burst_cfg_t c);
    logic [15:0] w;
    w = '0;
    w[LEN_LSB +: FIELD_W]  = c.len_code;
    w[BASE_LSB +: FIELD_W] = c.base_off;
    return w;
  endfunction

  // Pull the fields out of a written word, saturating the transfer-count code.
  function automatic burst_cfg_t unpack_cfg(logic [15:0] w, logic [FIELD_W-1:0] max_code);
    burst_cfg_t c;
    c.base_off = w[BASE_LSB +: FIELD_W];
    c.len_code = (w[LEN_LSB +: FIELD_W] > max_code) ? max_code : w[LEN_LSB +: FIELD_W];
    return c;
  endfunction
endpackage

// File: rtl/bdma_rst_sync.sv
module bdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/bdma_cfg.sv
module bdma_cfg
  import bdma_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int MAX_LEN_CODE = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              en_we,
  input  logic [DATA_W-1:0] wdata,
  output burst_cfg_t        cfg_o,
  output logic              upd_en_o
);
  localparam logic [FIELD_W-1:0] MAX_CODE = FIELD_W'(MAX_LEN_CODE);

  burst_cfg_t cfg_q, cfg_d;
  logic       en_q, en_d;

  always_comb begin
    cfg_d = cfg_q;
    en_d  = en_q;
    if (cfg_we) cfg_d = unpack_cfg(wdata[15:0], MAX_CODE);
    if (en_we)  en_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_d;
      if (en_we)  en_q  <= en_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign upd_en_o = en_q;
endmodule

// File: rtl/bdma_index.sv
module bdma_index #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [IDX_W-1:0] last_code,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_last;
  logic             upd;

  assign at_last = (idx_q == last_code);
  assign upd     = clr | step;

  always_comb begin
    idx_d = idx_q;
    if (clr)          idx_d = '0;
    else if (step)    idx_d = at_last ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx_q <= '0;
    else if (upd) idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign last_o = at_last;
endmodule

// File: rtl/bdma_req.sv
module bdma_req (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic burst_done,
  output logic req_o,
  output logic pend_o
);
  logic req_q, req_d;
  logic pend_q, pend_d;

  always_comb begin
    req_d  = req_q;
    pend_d = pend_q;
    if (burst_done) begin
      req_d  = pend_q | start;
      pend_d = pend_q & start;
    end else if (start) begin
      if (req_q) pend_d = 1'b1;
      else       req_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (burst_done | start) begin
      req_q  <= req_d;
      pend_q <= pend_d;
    end
  end

  assign req_o  = req_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/bdma_regfile.sv
module bdma_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/bdma_window_seq.sv
module bdma_window_seq
  import bdma_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int NUM_REGS     = 32,
  parameter int ADDR_W       = 6,
  parameter int MAX_LEN_CODE = 17,
  parameter int CFG_ADDR     = 32,
  parameter int WIN_ADDR     = 33,
  parameter int EN_ADDR      = 34
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              upd_evt,
  input  logic              dma_ack,
  output logic              dma_req
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_ADDR);
  localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_ADDR);

  logic             rst_s;
  burst_cfg_t       cfg;
  logic             upd_en;
  logic [IDX_W-1:0] idx;
  logic             idx_last;
  logic             pend;

  logic             cfg_hit, win_hit, en_hit, dir_hit;
  logic             acc, win_acc, dir_acc, cfg_we, en_we;
  logic             burst_done, start;
  logic [IDX_W-1:0] tgt;
  logic             rf_we;
  logic [IDX_W-1:0] rf_waddr;
  logic [DATA_W-1:0] rd_dir, rd_win;
  logic [DATA_W-1:0] rd_mux;

  bdma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_s)
  );

  // Address decode
  assign cfg_hit = (bus_addr == CFG_A);
  assign win_hit = (bus_addr == WIN_A);
  assign en_hit  = (bus_addr == EN_A);
  assign dir_hit = (bus_addr < ADDR_W'(NUM_REGS));
  assign acc     = bus_we | bus_re;
  assign win_acc = acc & win_hit;
  assign dir_acc = acc & dir_hit;
  assign cfg_we  = bus_we & cfg_hit;
  assign en_we   = bus_we & en_hit;

  // Moving target: start offset plus index, wrapping over the register file
  assign tgt = IDX_W'(cfg.base_off) + idx;

  assign burst_done = dma_req & win_acc & dma_ack & idx_last;
  assign start      = upd_evt & upd_en;

  bdma_cfg #(.DATA_W(DATA_W), .MAX_LEN_CODE(MAX_LEN_CODE)) u_cfg (
    .clk(clk), .rst_n(rst_s), .cfg_we(cfg_we), .en_we(en_we),
    .wdata(bus_wdata), .cfg_o(cfg), .upd_en_o(upd_en)
  );

  bdma_index #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_s), .clr(cfg_we), .step(win_acc),
    .last_code(IDX_W'(cfg.len_code)), .idx_o(idx), .last_o(idx_last)
  );

  bdma_req u_req (
    .clk(clk), .rst_n(rst_s), .start(start), .burst_done(burst_done),
    .req_o(dma_req), .pend_o(pend)
  );

  assign rf_we    = bus_we & (dir_hit | win_hit);
  assign rf_waddr = win_hit ? tgt : bus_addr[IDX_W-1:0];

  bdma_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_s), .we(rf_we), .waddr(rf_waddr), .wdata(bus_wdata),
    .raddr_a(bus_addr[IDX_W-1:0]), .rdata_a(rd_dir),
    .raddr_b(tgt), .rdata_b(rd_win)
  );

  // Read-data steering
  always_comb begin
    rd_mux = '0;
    if (dir_hit)      rd_mux = rd_dir;
    else if (win_hit) rd_mux = rd_win;
    else if (cfg_hit) rd_mux = DATA_W'(pack_cfg(cfg));
    else if (en_hit)  rd_mux = DATA_W'(upd_en);
  end

  assign bus_rdata = bus_re ? rd_mux : '0;
endmodule

// File: rtl/bdma_window_seq_chk.sv
module bdma_window_seq_chk #(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 6,
  parameter int IDX_W        = 5,
  parameter int MAX_LEN_CODE = 17,
  parameter int CFG_ADDR     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              win_acc,
  input logic              dir_acc,
  input logic              cfg_we,
  input logic              dma_ack,
  input logic              dma_req,
  input logic              upd_evt,
  input logic              upd_en,
  input logic              pend,
  input logic [IDX_W-1:0]  idx,
  input logic [4:0]        len_code,
  input logic              idx_last
);
  // R1: reserved bits of the configuration word never read as one
  p_cfg_rsv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(CFG_ADDR)) |-> (bus_rdata[15:13] == 3'b0 && bus_rdata[7:5] == 3'b0));

  // R2: stored code never exceeds the saturation limit
  p_len_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    len_code <= 5'(MAX_LEN_CODE));

  // R4: a window access away from the last index advances the index by one
  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !cfg_we && !idx_last) |=> (idx == IDX_W'($past(idx) + 1'b1)));

  // R5: the access at the last index wraps the index to zero
  p_idx_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !cfg_we && idx_last) |=> (idx == '0));

  // R6: request only rises after an armed update event
  p_req_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(upd_evt && upd_en));

  // R7: request only falls after the acknowledged last access
  p_req_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req) |-> $past(win_acc && dma_ack && idx_last));

  // R8: a pending event keeps the request up across the burst boundary
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && dma_req && win_acc && dma_ack && idx_last) |=> dma_req);

  // R9: direct accesses leave the index where it was
  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_acc && !win_acc && !cfg_we) |=> $stable(idx));

  // R10: writing the configuration returns the index to zero
  p_cfg_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (idx == '0));
endmodule

bind bdma_window_seq bdma_window_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
  .MAX_LEN_CODE(MAX_LEN_CODE), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_s), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .win_acc(win_acc), .dir_acc(dir_acc), .cfg_we(cfg_we),
  .dma_ack(dma_ack), .dma_req(dma_req), .upd_evt(upd_evt), .upd_en(upd_en),
  .pend(pend), .idx(idx), .len_code(cfg.len_code), .idx_last(idx_last)
);

// File: tb/bdma_window_seq_tb.sv
`timescale 1ns/100ps
module bdma_window_seq_tb;
  localparam int CFG_A = 32;
  localparam int WIN_A = 33;
  localparam int EN_A  = 34;

  logic        clk;
  logic        arst_n;
  logic [5:0]  bus_addr;
  logic        bus_we, bus_re;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        upd_evt, dma_ack;
  logic        dma_req;

  int n_run;
  int n_fail;
  logic [15:0] model [32];

  bdma_window_seq u_dut (
    .clk(clk), .arst_n(arst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_evt(upd_evt), .dma_ack(dma_ack), .dma_req(dma_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    upd_evt = 1'b0; dma_ack = 1'b0;
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic ack);
    @(negedge clk);
    bus_addr = 6'(a); bus_wdata = d; bus_we = 1'b1; dma_ack = ack;
    @(posedge clk);
    #1 idle_bus();
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = 6'(a); bus_re = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 idle_bus();
  endtask

  task automatic pulse_upd();
    @(negedge clk);
    upd_evt = 1'b1;
    @(posedge clk);
    #1 idle_bus();
  endtask

  task automatic chk_req(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {15'b0, dma_req}, {15'b0, exp});
  endtask

  function automatic logic [15:0] cfg_word(input int code, input int base);
    return 16'((code << 8) | base);
  endfunction

  // One acknowledged burst of window writes; model tracks where each word lands.
  task automatic burst(input int base, input int code, input int seed);
    for (int k = 0; k <= code; k++) begin
      logic [15:0] d;
      d = 16'(seed * 97 + base * 31 + k * 7 + 1);
      if (k != 0) chk_req("R7 req held mid-burst", 1'b1);
      wr(WIN_A, d, 1'b1);
      model[(base + k) % 32] = d;
    end
  endtask

  task automatic verify_all(input string tag);
    for (int r = 0; r < 32; r++) begin
      logic [15:0] d;
      rd(r, d);
      check(tag, d, model[r]);
    end
  endtask

  initial begin
    logic [15:0] d;
    n_run = 0; n_fail = 0;
    idle_bus();
    for (int r = 0; r < 32; r++) model[r] = '0;
    arst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R11 reset state
    chk_req("R11 req low after reset", 1'b0);
    rd(CFG_A, d); check("R11 cfg reset", d, 16'h0000);
    rd(EN_A, d);  check("R11 enable reset", d, 16'h0000);
    verify_all("R11 target reset");

    // R1 layout and reserved bits
    wr(CFG_A, 16'hE0E0, 1'b0); rd(CFG_A, d); check("R1 reserved ignored", d, 16'h0000);
    wr(CFG_A, 16'h0A05, 1'b0); rd(CFG_A, d); check("R1 field layout", d, 16'h0A05);
    // R2 clamp
    wr(CFG_A, 16'hFFFF, 1'b0); rd(CFG_A, d); check("R2 clamp all-ones", d, 16'h111F);
    wr(CFG_A, 16'h1200, 1'b0); rd(CFG_A, d); check("R2 clamp code 18", d, 16'h1100);

    // R12 unmapped space
    wr(40, 16'hBEEF, 1'b0); rd(40, d); check("R12 unmapped read", d, 16'h0000);
    wr(63, 16'h1234, 1'b0); rd(63, d); check("R12 unmapped read 63", d, 16'h0000);
    rd(CFG_A, d); check("R12 cfg untouched", d, 16'h1100);
    verify_all("R12 targets untouched");

    // R6 disarmed update path
    wr(CFG_A, cfg_word(2, 0), 1'b0);
    pulse_upd(); chk_req("R6 no request when disarmed", 1'b0);
    wr(EN_A, 16'h0001, 1'b0); rd(EN_A, d); check("R6 enable readback", d, 16'h0001);

    // Near-exhaustive sweep: every start offset with short, mid and maximum bursts
    for (int base = 0; base < 32; base++) begin
      for (int ci = 0; ci < 3; ci++) begin
        int code;
        code = (ci == 0) ? 0 : (ci == 1) ? 2 : 17;
        wr(CFG_A, cfg_word(code, base), 1'b0);
        pulse_upd();
        chk_req("R6 request raised", 1'b1);
        burst(base, code, base * 3 + ci);
        chk_req("R7 request dropped", 1'b0);
        for (int k = 0; k <= code; k++) begin
          rd((base + k) % 32, d);
          check("R3 direct readback of burst target", d, model[(base + k) % 32]);
        end
        for (int k = 0; k <= code; k++) begin
          rd(WIN_A, d);
          check("R4 window read walks targets", d, model[(base + k) % 32]);
        end
        rd(WIN_A, d);
        check("R5 index wrapped to start", d, model[base]);
      end
    end
    verify_all("R3 full file after sweep");

    // R5 repeated bursts hit the same registers, wrapping past 31
    wr(CFG_A, cfg_word(2, 30), 1'b0);
    pulse_upd(); burst(30, 2, 500); chk_req("R7 first burst done", 1'b0);
    pulse_upd(); burst(30, 2, 600); chk_req("R7 second burst done", 1'b0);
    rd(30, d); check("R5 second burst reg 30", d, model[30]);
    rd(0, d);  check("R5 second burst wraps to reg 0", d, model[0]);

    // R8 pending update during a burst
    wr(CFG_A, cfg_word(2, 4), 1'b0);
    pulse_upd();
    wr(WIN_A, 16'hA001, 1'b1); model[4] = 16'hA001;
    pulse_upd();
    wr(WIN_A, 16'hA002, 1'b1); model[5] = 16'hA002;
    wr(WIN_A, 16'hA003, 1'b1); model[6] = 16'hA003;
    chk_req("R8 request held for pending burst", 1'b1);
    burst(4, 2, 700);
    chk_req("R8 request drops after pending burst", 1'b0);
    verify_all("R8 targets after pending burst");

    // R10 configuration write restarts the index
    wr(CFG_A, cfg_word(5, 8), 1'b0);
    wr(WIN_A, 16'hC001, 1'b0); model[8] = 16'hC001;
    wr(WIN_A, 16'hC002, 1'b0); model[9] = 16'hC002;
    wr(CFG_A, cfg_word(5, 8), 1'b0);
    wr(WIN_A, 16'hC003, 1'b0); model[8] = 16'hC003;
    rd(8, d);  check("R10 index cleared by cfg write", d, 16'hC003);
    rd(10, d); check("R10 next register untouched", d, model[10]);

    // R9 direct accesses do not move the index (index now 1)
    wr(20, 16'hD020, 1'b0); model[20] = 16'hD020;
    rd(3, d); check("R9 direct read", d, model[3]);
    wr(WIN_A, 16'hD009, 1'b0); model[9] = 16'hD009;
    rd(9, d);  check("R9 window lands after direct traffic", d, 16'hD009);
    rd(20, d); check("R9 direct write", d, 16'hD020);
    verify_all("R9 final file");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule